// File: doc/BRIEF.md
# Register-Driven SPI Host Shifter

This block is a SPI host controlled through a small synchronous register port. Software first places up to 32 bits of transmit data in an output register. It then writes one command word, and that word starts the transfer. The command word picks one of three active-low chip selects, gives a bit count and carries an end-of-frame flag. The engine then generates the serial clock from a programmable divider. It sends the data most significant bit first and gathers the bits returned on the input line into a receive register. It drops the command's busy flag when the last bit has been sent.

A long frame can be split across several commands. Each command except the last is issued with the end-of-frame flag clear, so the chip select stays low between commands. The last command is issued with the flag set, and the chip select rises when that command finishes. While the bus is idle, a pin-level register sets the chip-select and data-out levels. A global enable bit gates all command traffic.

Top module: `spi_shift_host`

## Requirements
- R1: After reset the enable register reads 0, the divider register reads 0, the pin-level register reads 0x00070000, the busy bit reads 0, all chip selects are high and both SCK and MOSI are low.
- R2: The register offsets are: enable at 0x00 (bit 0 only), divider at 0x04 (bits 5:0 only), pin levels at 0x08, transmit data at 0x10, command at 0x14 and receive data at 0x18. The enable, divider and transmit registers read back what was written, masked to their widths.
- R3: A command write is accepted only when the enable bit is 1 and busy is 0. Busy (command bit 31) reads 1 from the cycle after acceptance for exactly 2·N·(D+1) cycles, where N is the effective bit count and D is the divider.
- R4: SCK idles low. Its first rising edge comes D+1 cycles after the accepting clock edge, and edges of either polarity are D+1 cycles apart.
- R5: MOSI sends the low N bits of the transmit register, most significant bit first. It changes only on falling SCK edges.
- R6: MISO is sampled on each rising SCK edge. The receive register is cleared when a shift with N>0 starts, and the received bits shift in from bit 0, so the last bit lands in bit 0.
- R7: Command bits 30:28 select chip selects 2:0, and the selected lines go low for the whole shift. If end-of-frame (bit 26) is 1, the lines rise after the last falling edge. If it is 0, they stay low after busy clears.
- R8: The count field is bits 6:0. A count of 0 produces no SCK edges and never raises busy. Counts above 32 behave as 32.
- R9: A command write while busy is 1 is ignored, including a write on the very clock edge at which the shift finishes.
- R10: While the enable bit is 0, command writes are ignored and all chip selects follow their idle levels. Clearing the enable bit during a shift abandons it, and SCK returns low.
- R11: The receive register keeps its value until a shift with N>0 starts. Register writes and zero-count commands do not change it.
- R12: While no chip select is held, chip select i follows pin-level bit 16+i. While not busy, MOSI follows pin-level bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Byte address for both read and write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data |
| spiSck | output | 1 | Serial clock |
| spiMosi | output | 1 | Host-to-device data |
| spiMiso | input | 1 | Device-to-host data |
| spiCsN | output | 3 | Active-low chip selects |

## Verification
Two events can fall on the same clock edge: a shift finishing, which clears busy and may release the chip select, and a new command write arriving. The bench computes the finishing cycle from 2·N·(D+1) and places a command write on exactly that edge. It then expects no further SCK edges, a clear busy bit, released chip selects and an unchanged receive word. A second collision sets the enable bit to 0 in the middle of a shift, and the bench expects the chip selects to rise and SCK to drop while fewer than N rising edges have occurred.

// File: rtl/spi_shift_pkg.sv
package spi_shift_pkg;
  localparam int REG_W       = 32;
  localparam int ADDR_W      = 5;
  localparam int BIT_CNT_W   = $clog2(REG_W) + 1;
  localparam int CNT_FIELD_W = 7;
  localparam int GO_BIT      = 31;
  localparam int CS_LSB      = 28;
  localparam int TERM_BIT    = 26;
  localparam int IDLE_CS_LSB = 16;
  localparam int IDLE_MOSI   = 0;

  localparam logic [ADDR_W-1:0] OFS_ENABLE = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV    = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_PINS   = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_TXD    = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_CMD    = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_RXD    = 5'h18;

  localparam logic [REG_W-1:0] PINS_RESET = 32'h0007_0000;

  // control -> datapath strobes
  typedef struct packed {
    logic                 load;
    logic [BIT_CNT_W-1:0] loadBits;
    logic                 sample;
    logic                 shift;
  } shiftStrobe_t;
endpackage

// File: rtl/spi_shift_dp.sv
module spi_shift_dp
  import spi_shift_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int CS_COUNT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   regWrEn,
  input  logic [ADDR_W-1:0]      regAddr,
  input  logic [REG_W-1:0]       regWrData,
  output logic [REG_W-1:0]       regRdData,
  input  shiftStrobe_t           strobe,
  input  logic                   busy,
  input  logic                   miso,
  output logic                   enable,
  output logic [DIV_W-1:0]       divider,
  output logic                   cmdWrite,
  output logic [CS_COUNT-1:0]    cmdCs,
  output logic                   cmdTerm,
  output logic [CNT_FIELD_W-1:0] cmdCount,
  output logic [CS_COUNT-1:0]    csIdle,
  output logic                   mosiIdle,
  output logic                   txBit
);
  localparam logic [BIT_CNT_W-1:0] FULL_BITS = BIT_CNT_W'(REG_W);

  logic                   enReg;
  logic [DIV_W-1:0]       divReg;
  logic [REG_W-1:0]       pinReg;
  logic [REG_W-1:0]       txDataReg;
  logic [REG_W-1:0]       txShift;
  logic [REG_W-1:0]       rxShift;
  logic [CS_COUNT-1:0]    lastCs;
  logic                   lastTerm;
  logic [CNT_FIELD_W-1:0] lastCnt;
  logic [REG_W-1:0]       cmdView;

  assign enable   = enReg;
  assign divider  = divReg;
  assign cmdWrite = regWrEn && (regAddr == OFS_CMD);
  assign cmdCs    = regWrData[CS_LSB +: CS_COUNT];
  assign cmdTerm  = regWrData[TERM_BIT];
  assign cmdCount = regWrData[CNT_FIELD_W-1:0];
  assign csIdle   = pinReg[IDLE_CS_LSB +: CS_COUNT];
  assign mosiIdle = pinReg[IDLE_MOSI];
  assign txBit    = txShift[REG_W-1];

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enReg     <= 1'b0;
      divReg    <= '0;
      pinReg    <= PINS_RESET;
      txDataReg <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        OFS_ENABLE: enReg     <= regWrData[0];
        OFS_DIV:    divReg    <= regWrData[DIV_W-1:0];
        OFS_PINS:   pinReg    <= regWrData;
        OFS_TXD:    txDataReg <= regWrData;
        default: ;
      endcase
    end
  end

  // readback copy of the last accepted command fields
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lastCs   <= '0;
      lastTerm <= 1'b0;
      lastCnt  <= '0;
    end else if (cmdWrite && enReg && !busy) begin
      lastCs   <= cmdCs;
      lastTerm <= cmdTerm;
      lastCnt  <= cmdCount;
    end
  end

  // transmit shifter: left-justify the low N bits so bit 31 goes out first
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      txShift <= '0;
    end else if (strobe.load) begin
      txShift <= txDataReg << (FULL_BITS - strobe.loadBits);
    end else if (strobe.shift) begin
      txShift <= {txShift[REG_W-2:0], 1'b0};
    end
  end

  // receive shifter: right-aligned assembly
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxShift <= '0;
    end else if (strobe.load) begin
      rxShift <= '0;
    end else if (strobe.sample) begin
      rxShift <= {rxShift[REG_W-2:0], miso};
    end
  end

  always_comb begin
    cmdView                          = '0;
    cmdView[GO_BIT]                  = busy;
    cmdView[CS_LSB +: CS_COUNT]      = lastCs;
    cmdView[TERM_BIT]                = lastTerm;
    cmdView[CNT_FIELD_W-1:0]         = lastCnt;
  end

  always_comb begin
    case (regAddr)
      OFS_ENABLE: regRdData = REG_W'(enReg);
      OFS_DIV:    regRdData = REG_W'(divReg);
      OFS_PINS:   regRdData = pinReg;
      OFS_TXD:    regRdData = txDataReg;
      OFS_CMD:    regRdData = cmdView;
      OFS_RXD:    regRdData = rxShift;
      default:    regRdData = '0;
    endcase
  end

  // R11: receive word only moves on a load or a sample
  assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.load && !strobe.sample) |=> $stable(rxShift));

  // R9: a new shift may only be loaded while the engine is idle
  assert_load_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.load |-> !busy);

  // R6: sampling happens only inside a shift
  assert_sample_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.sample |-> busy);
endmodule

// File: rtl/spi_shift_ctrl.sv
module spi_shift_ctrl
  import spi_shift_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int CS_COUNT = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic [DIV_W-1:0]       divider,
  input  logic                   cmdWrite,
  input  logic [CS_COUNT-1:0]    cmdCs,
  input  logic                   cmdTerm,
  input  logic [CNT_FIELD_W-1:0] cmdCount,
  output shiftStrobe_t           strobe,
  output logic                   busy,
  output logic                   sckLevel,
  output logic [CS_COUNT-1:0]    csHeld
);
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} state_t;

  localparam logic [BIT_CNT_W-1:0]   FULL_BITS = BIT_CNT_W'(REG_W);
  localparam logic [CNT_FIELD_W-1:0] FULL_CNT  = CNT_FIELD_W'(REG_W);

  state_t               state;
  logic [DIV_W-1:0]     halfCnt;
  logic [BIT_CNT_W-1:0] bitsLeft;
  logic                 termReg;
  logic                 sckReg;
  logic [BIT_CNT_W-1:0] reqBits;
  logic                 halfDone;
  logic                 accept;
  logic                 lastEdge;

  assign reqBits  = (cmdCount > FULL_CNT) ? FULL_BITS : cmdCount[BIT_CNT_W-1:0];
  assign halfDone = (halfCnt == divider);
  assign accept   = cmdWrite && enable && (state == ST_IDLE);
  assign lastEdge = (state == ST_HIGH) && halfDone && (bitsLeft == BIT_CNT_W'(1));

  assign busy     = (state != ST_IDLE);
  assign sckLevel = sckReg;

  always_comb begin
    strobe.load     = accept && (reqBits != '0);
    strobe.loadBits = reqBits;
    strobe.sample   = (state == ST_LOW) && halfDone && enable;
    strobe.shift    = (state == ST_HIGH) && halfDone && !lastEdge && enable;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      halfCnt  <= '0;
      bitsLeft <= '0;
      termReg  <= 1'b0;
      sckReg   <= 1'b0;
      csHeld   <= '0;
    end else if (!enable) begin
      state   <= ST_IDLE;
      halfCnt <= '0;
      sckReg  <= 1'b0;
      csHeld  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cmdWrite) begin
            termReg <= cmdTerm;
            if (reqBits == '0) begin
              csHeld <= cmdTerm ? '0 : cmdCs;
            end else begin
              csHeld   <= cmdCs;
              state    <= ST_LOW;
              halfCnt  <= '0;
              bitsLeft <= reqBits;
            end
          end
        end
        ST_LOW: begin
          if (halfDone) begin
            state   <= ST_HIGH;
            sckReg  <= 1'b1;
            halfCnt <= '0;
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            sckReg  <= 1'b0;
            halfCnt <= '0;
            if (lastEdge) begin
              state <= ST_IDLE;
              if (termReg) csHeld <= '0;
            end else begin
              state    <= ST_LOW;
              bitsLeft <= bitsLeft - BIT_CNT_W'(1);
            end
          end else begin
            halfCnt <= halfCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: SCK is low whenever the engine is idle
  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sckLevel);

  // R4: SCK toggles only after a full half period while enabled
  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sckLevel) && $past(enable)) |-> ($past(halfCnt) == $past(divider)));

  // R3: busy never drops with SCK still high
  assert_finish_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sckLevel);

  // R10: disabling releases every held chip select
  assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (csHeld == '0));

  // R9: a command during a shift (not its final edge) changes nothing visible
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && busy && cmdWrite && !lastEdge) |=> (busy && $stable(csHeld)));
endmodule

// File: rtl/spi_shift_host.sv
module spi_shift_host
  import spi_shift_pkg::*;
#(
  parameter int DIV_W    = 6,
  parameter int CS_COUNT = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [REG_W-1:0]    regWrData,
  output logic [REG_W-1:0]    regRdData,
  output logic                spiSck,
  output logic                spiMosi,
  input  logic                spiMiso,
  output logic [CS_COUNT-1:0] spiCsN
);
  shiftStrobe_t           strobe;
  logic                   busy;
  logic                   sckLevel;
  logic [CS_COUNT-1:0]    csHeld;
  logic                   enable;
  logic [DIV_W-1:0]       divider;
  logic                   cmdWrite;
  logic [CS_COUNT-1:0]    cmdCs;
  logic                   cmdTerm;
  logic [CNT_FIELD_W-1:0] cmdCount;
  logic [CS_COUNT-1:0]    csIdle;
  logic                   mosiIdle;
  logic                   txBit;

  spi_shift_dp #(.DIV_W(DIV_W), .CS_COUNT(CS_COUNT)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .strobe    (strobe),
    .busy      (busy),
    .miso      (spiMiso),
    .enable    (enable),
    .divider   (divider),
    .cmdWrite  (cmdWrite),
    .cmdCs     (cmdCs),
    .cmdTerm   (cmdTerm),
    .cmdCount  (cmdCount),
    .csIdle    (csIdle),
    .mosiIdle  (mosiIdle),
    .txBit     (txBit)
  );

  spi_shift_ctrl #(.DIV_W(DIV_W), .CS_COUNT(CS_COUNT)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .divider  (divider),
    .cmdWrite (cmdWrite),
    .cmdCs    (cmdCs),
    .cmdTerm  (cmdTerm),
    .cmdCount (cmdCount),
    .strobe   (strobe),
    .busy     (busy),
    .sckLevel (sckLevel),
    .csHeld   (csHeld)
  );

  assign spiSck  = sckLevel;
  assign spiMosi = busy ? txBit : mosiIdle;

  for (genvar i = 0; i < CS_COUNT; i++) begin : g_cs
    assign spiCsN[i] = (csHeld[i] && enable) ? 1'b0 : csIdle[i];
  end
endmodule

// File: tb/spi_shift_host_tb.sv
module spi_shift_host_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWrEn = 1'b0;
  logic [4:0]  regAddr = 5'h0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        spiSck, spiMosi, spiMiso;
  logic [2:0]  spiCsN;

  spi_shift_host u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .spiSck(spiSck),
    .spiMosi(spiMosi), .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  always #4 clk = ~clk;

  int checks = 0, failures = 0;
  bit finished = 1'b0;
  int cyc = 0, rises = 0, falls = 0, firstRise = 0, lastRise = 0, csErr = 0;
  int cmdCyc = 0, slaveN = 0;
  logic [31:0] slavePat = '0, benchMosi = '0, lastRx = '0;
  logic [2:0]  expCs = 3'b111;
  logic        prevSck = 1'b0;

  assign spiMiso = (falls < slaveN) ? slavePat[slaveN-1-falls] : 1'b0;

  // pin monitor, sampled on the falling clock edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (spiSck && !prevSck) begin
      rises = rises + 1;
      if (rises == 1) firstRise = cyc;
      lastRise = cyc;
      benchMosi = {benchMosi[30:0], spiMosi};
      if (spiCsN != expCs) csErr = csErr + 1;
    end
    if (!spiSck && prevSck) falls = falls + 1;
    prevSck = spiSck;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic nextCyc(input int k);
    for (int i = 0; i < k; i++) begin @(negedge clk); #1; end
  endtask

  task automatic pulseWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    regAddr = a; regWrData = d; regWrEn = 1'b1; cmdCyc = cyc;
    @(negedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    regAddr = a; #1; v = regRdData;
  endtask

  function automatic logic [31:0] cmdWord(input int cs, input bit term, input int cnt);
    return 32'h8000_0000 | (32'h1 << (28 + cs)) | (32'(term) << 26) | (32'(cnt) & 32'h7f);
  endfunction

  function automatic logic [31:0] maskN(input int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 32'h1);
  endfunction

  task automatic arm(input int n, input logic [31:0] pat, input int cs);
    rises = 0; falls = 0; firstRise = 0; lastRise = 0; csErr = 0;
    benchMosi = '0; slaveN = n; slavePat = pat;
    expCs = 3'b111 & ~(3'b001 << cs);
  endtask

  task automatic doShift(input int d, input int cs, input bit term, input int cnt,
                         input logic [31:0] tx, input logic [31:0] rxPat);
    int n, t, goErr;
    logic [31:0] v;
    n = (cnt > 32) ? 32 : cnt;
    t = 2 * n * (d + 1);
    pulseWrite(5'h04, 32'(d));
    pulseWrite(5'h10, tx);
    arm(n, rxPat, cs);
    pulseWrite(5'h14, cmdWord(cs, term, cnt));
    goErr = 0;
    for (int k = 1; k <= t + 1; k++) begin
      rd(5'h14, v);
      if (v[31] != (k <= t)) goErr++;
      if (k <= t) nextCyc(1);
    end
    chk(goErr == 0, "R3 busy window", 32'(goErr), 0);
    chk(rises == n && falls == n, "R8 edge count", 32'(rises), 32'(n));
    if (n > 0) begin
      chk(firstRise == cmdCyc + d + 2, "R4 first rise", 32'(firstRise - cmdCyc), 32'(d + 2));
      chk(lastRise == cmdCyc + (2*n - 1)*(d + 1) + 1, "R4 last rise",
          32'(lastRise - cmdCyc), 32'((2*n - 1)*(d + 1) + 1));
      chk(benchMosi == (tx & maskN(n)), "R5 mosi word", benchMosi, tx & maskN(n));
      lastRx = rxPat & maskN(n);
      chk(csErr == 0, "R7 cs during shift", 32'(csErr), 0);
    end
    rd(5'h18, v);
    chk(v == lastRx, "R6 rx word", v, lastRx);
    chk(spiCsN == (term ? 3'b111 : expCs), "R7 cs after", 32'(spiCsN), 32'(term ? 3'b111 : expCs));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int idx;
    nextCyc(3);
    rst_n = 1'b1;
    nextCyc(1);
    // R1 reset state
    rd(5'h00, v); chk(v == 0, "R1 enable reset", v, 0);
    rd(5'h04, v); chk(v == 0, "R1 divider reset", v, 0);
    rd(5'h08, v); chk(v == 32'h0007_0000, "R1 pins reset", v, 32'h0007_0000);
    rd(5'h14, v); chk(v[31] == 1'b0, "R1 busy reset", 32'(v[31]), 0);
    chk(spiCsN == 3'b111 && !spiSck && !spiMosi, "R1 pin levels",
        {28'h0, spiCsN, spiSck}, 32'he);

    // R10 disabled: command ignored
    arm(8, 32'hFF, 0);
    pulseWrite(5'h14, cmdWord(0, 1'b0, 8));
    nextCyc(20);
    rd(5'h14, v);
    chk(rises == 0 && v[31] == 1'b0 && spiCsN == 3'b111, "R10 disabled cmd", 32'(rises), 0);

    // R2 register map
    pulseWrite(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk(v == 32'h3F, "R2 divider mask", v, 32'h3F);
    pulseWrite(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); chk(v == 32'h1, "R2 enable mask", v, 1);
    pulseWrite(5'h10, 32'hCAFE_F00D);
    rd(5'h10, v); chk(v == 32'hCAFE_F00D, "R2 txd readback", v, 32'hCAFE_F00D);

    // R12 idle pin levels
    pulseWrite(5'h08, 32'h0005_0001);
    nextCyc(1);
    chk(spiCsN == 3'b101 && spiMosi, "R12 idle levels", {28'h0, spiCsN, spiMosi}, 32'hB);
    pulseWrite(5'h08, 32'h0007_0000);

    // sweep: dividers x counts, rotating chip select, alternating end-of-frame
    idx = 0;
    for (int di = 0; di < 4; di++) begin
      for (int ci = 0; ci < 8; ci++) begin
        int d, cnt;
        logic [31:0] tx, rxp;
        d = (di == 3) ? 5 : di;
        case (ci)
          0: cnt = 0;   1: cnt = 1;  2: cnt = 8;  3: cnt = 16;
          4: cnt = 24;  5: cnt = 32; 6: cnt = 40; default: cnt = 127;
        endcase
        tx  = 32'(32'h9E37_79B9 * (idx + 1));
        rxp = {tx[12:0], tx[31:13]} ^ 32'h5A5A_A5A5;
        doShift(d, idx % 3, bit'(idx % 2), cnt, tx, rxp);
        idx++;
      end
    end
    // slowest divider
    doShift(63, 1, 1'b1, 8, 32'h0000_00B4, 32'h0000_0069);

    // R11 receive word held across writes and zero-count command
    pulseWrite(5'h10, 32'h1234_5678);
    pulseWrite(5'h04, 32'h2);
    pulseWrite(5'h14, cmdWord(2, 1'b1, 0));
    nextCyc(2);
    rd(5'h18, v); chk(v == lastRx, "R11 rx held", v, lastRx);

    // R9 commands while busy, including one on the finishing edge
    pulseWrite(5'h04, 32'h1);
    pulseWrite(5'h10, 32'h0000_00C3);
    arm(8, 32'h0000_003C, 0);
    pulseWrite(5'h14, cmdWord(0, 1'b1, 8));   // k=1 after return
    nextCyc(1);                                 // k=2
    pulseWrite(5'h14, cmdWord(1, 1'b0, 16));  // set at k=3
    nextCyc(32 - 5);                            // k=31
    pulseWrite(5'h14, cmdWord(2, 1'b1, 8));   // set at k=32, the finishing edge
    nextCyc(20);
    rd(5'h14, v);
    chk(rises == 8 && v[31] == 1'b0, "R9 busy writes ignored", 32'(rises), 8);
    chk(spiCsN == 3'b111 && csErr == 0, "R9 cs after collision", 32'(spiCsN), 32'h7);
    rd(5'h18, v); chk(v == 32'h3C, "R9 rx after collision", v, 32'h3C);
    chk(benchMosi == 32'hC3, "R5 mosi after collision", benchMosi, 32'hC3);
    lastRx = 32'h3C;

    // R10 disable releases held chip select
    doShift(0, 2, 1'b0, 8, 32'h0000_0011, 32'h0000_0022);
    pulseWrite(5'h00, 32'h0);
    chk(spiCsN == 3'b111, "R10 disable releases cs", 32'(spiCsN), 32'h7);
    pulseWrite(5'h00, 32'h1);
    nextCyc(1);
    chk(spiCsN == 3'b111, "R10 cs stays released", 32'(spiCsN), 32'h7);

    // R10 disable mid-shift abandons it
    pulseWrite(5'h04, 32'h2);
    arm(16, 32'hFFFF, 1);
    pulseWrite(5'h14, cmdWord(1, 1'b1, 16));
    nextCyc(10);
    pulseWrite(5'h00, 32'h0);
    nextCyc(2);
    rd(5'h14, v);
    chk(v[31] == 1'b0 && !spiSck && spiCsN == 3'b111 && rises < 16,
        "R10 abort mid shift", 32'(rises), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule